// File: doc/BRIEF.md
# Disc Controller Host Register Port

This block is the byte-wide host-facing register port of an optical-disc controller. A host processor sees four byte offsets. Offset 0 carries a 2-bit bank index; the bank index chooses which internal register each of offsets 1, 2 and 3 reaches on a read or a write. Behind the port sit a parameter queue, a response queue, a 5-bit interrupt flag register, its 5-bit enable mask and four audio-mix attenuation bytes.

The host queues command parameters and then writes a command byte. The command is handed to an external sequencer as a one-cycle valid pulse with the byte. The sequencer drains parameters, fills the response queue, raises interrupt flag bits and reports its busy and data-available state. The host reads a status byte, pops responses, acknowledges interrupts by writing ones to a clear register and can flush the parameter queue. Each queue has 16 entries and 5-bit pointers that wrap. Overfilling a queue folds silently onto older entries, and the fill count is taken modulo 32.

Top module: `disc_host_port`

## Requirements
- R1: After reset the status byte reads 0x18, the interrupt output is low, mask and flag reads return 0xE0, the command valid is low and all mix outputs are 0.
- R2: A write to offset 0 loads data bits 1:0 as the bank index, which the status byte returns in bits 1:0.
- R3: Status bit 3 is set when the parameter queue is empty, bit 4 when it is not full, bit 5 when the response queue is not empty, bit 6 follows the data-available input, bit 7 follows the busy input and bit 2 is 0.
- R4: A write to offset 2 in bank 0 appends a parameter; the queue holds 16 bytes in arrival order, reports full at 16, and a sequencer pop removes the head byte.
- R5: A push beyond full overwrites the slot at the write pointer without error: after 17 pushes into an empty queue the head is the 17th byte and the queue reads neither empty nor full; after 32 pushes it reads empty.
- R6: A read of offset 1 returns the response head and pops it; when the response queue is empty the read returns the byte at the read pointer and leaves the pointer in place.
- R7: A read of offset 3 returns the mask with bits 7:5 set in bank 0 and the flags with bits 7:5 set in bank 1.
- R8: A write to offset 3 in bank 1 clears each flag bit whose data bit in 4:0 is 1, and when data bit 6 is 1 it empties the parameter queue.
- R9: A write to offset 2 in bank 1 loads data bits 4:0 into the mask; the interrupt output is high exactly when flags AND mask is nonzero.
- R10: A write to offset 1 in bank 0 gives a command-valid pulse of one cycle on the next cycle together with the written byte; writes to offset 1 in other banks give no pulse.
- R11: Attenuation writes land as follows: offset 2 bank 2 on left-to-left, offset 3 bank 2 on left-to-right, offset 2 bank 3 on right-to-left, offset 1 bank 3 on right-to-right; no other write changes them.
- R12: A sequencer flag-set ORs its 5-bit code into the flags, and in a cycle where a clear write and a set coincide the set bits remain set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Host register offset |
| busWrEn | input | 1 | Host write strobe |
| busWrData | input | 8 | Host write data |
| busRdEn | input | 1 | Host read strobe (pops on offset 1) |
| busRdData | output | 8 | Host read data, combinational from offset and bank |
| busyIn | input | 1 | Sequencer busy, shown in status bit 7 |
| dataAvailIn | input | 1 | Sector data available, shown in status bit 6 |
| irqSetEn | input | 1 | Sequencer flag-set strobe |
| irqSetCode | input | 5 | Flag bits to set |
| rspPushEn | input | 1 | Sequencer response push strobe |
| rspPushData | input | 8 | Response byte |
| parPopEn | input | 1 | Sequencer parameter pop strobe |
| parHead | output | 8 | Parameter queue head byte |
| cmdValid | output | 1 | One-cycle command pulse |
| cmdByte | output | 8 | Last command byte written |
| irqOut | output | 1 | Level interrupt |
| mixLeftLeft | output | 8 | Left-to-left attenuation |
| mixLeftRight | output | 8 | Left-to-right attenuation |
| mixRightLeft | output | 8 | Right-to-left attenuation |
| mixRightRight | output | 8 | Right-to-right attenuation |

## Verification
The hardest state to reach is pointer wrap-around: the queue must be pushed past full so the carry bit and the folded slot index diverge, and the bench drives 17 and then 32 host pushes and reads the head and status between them. Reading an empty response queue is reached by filling all 16 slots through the sequencer side and draining them, so the read pointer sits on a slot holding known data. The coincidence of a clear write with a sequencer flag-set is produced by one stimulus step that drives both in the same cycle.

// File: rtl/hostregs_pkg.sv
package hostregs_pkg;
  localparam int DATA_W  = 8;
  localparam int FLAG_W  = 5;
  localparam int MIX_N   = 4;
  localparam int MIX_LL  = 0;
  localparam int MIX_LR  = 1;
  localparam int MIX_RL  = 2;
  localparam int MIX_RR  = 3;

  typedef struct packed {
    logic             wrCmd;
    logic             pushPar;
    logic             wrMask;
    logic             wrClr;
    logic             popRsp;
    logic [MIX_N-1:0] wrMix;
  } hrStrobes_t;
endpackage

// File: rtl/hr_fifo.sv
module hr_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] CARRY = PW'(1) << AW;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [PW-1:0]    fillCnt;
  logic             doPop;

  assign empty   = (wrPtr == rdPtr);
  assign full    = ((wrPtr ^ rdPtr) == CARRY);
  assign fillCnt = wrPtr - rdPtr;
  assign doPop   = pop && !empty;
  assign head    = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wrPtr[AW-1:0]] <= pushData;
        wrPtr <= wrPtr + PW'(1);
      end
      if (doPop) rdPtr <= rdPtr + PW'(1);
    end
  end

  a_r4_not_empty_and_full: assert property (@(posedge clk) disable iff (!rstN)
    !(empty && full));

  a_r5_push_count_mod: assert property (@(posedge clk) disable iff (!rstN)
    push && !pop && !clr |=> fillCnt == $past(fillCnt) + PW'(1));

  a_r6_empty_pop_holds: assert property (@(posedge clk) disable iff (!rstN)
    pop && empty && !clr |=> rdPtr == $past(rdPtr));
endmodule

// File: rtl/hr_ctrl.sv
module hr_ctrl
  import hostregs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [1:0]        bankIdx,
  output hrStrobes_t        strb
);
  always_ff @(posedge clk) begin
    if (!rstN)                        bankIdx <= '0;
    else if (busWrEn && busAddr == 2'd0) bankIdx <= busWrData[1:0];
  end

  always_comb begin
    strb = '0;
    strb.popRsp = busRdEn && (busAddr == 2'd1);
    if (busWrEn) begin
      unique case (busAddr)
        2'd1: begin
          if (bankIdx == 2'd0) strb.wrCmd = 1'b1;
          if (bankIdx == 2'd3) strb.wrMix[MIX_RR] = 1'b1;
        end
        2'd2: begin
          unique case (bankIdx)
            2'd0: strb.pushPar = 1'b1;
            2'd1: strb.wrMask  = 1'b1;
            2'd2: strb.wrMix[MIX_LL] = 1'b1;
            2'd3: strb.wrMix[MIX_RL] = 1'b1;
          endcase
        end
        2'd3: begin
          if (bankIdx == 2'd1) strb.wrClr = 1'b1;
          if (bankIdx == 2'd2) strb.wrMix[MIX_LR] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  a_r2_index_load: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == 2'd0 |=> bankIdx == $past(busWrData[1:0]));

  a_r2_index_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == 2'd0) |=> $stable(bankIdx));
endmodule

// File: rtl/hr_datapath.sv
module hr_datapath
  import hostregs_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  hrStrobes_t        strb,
  input  logic [1:0]        bankIdx,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              busyIn,
  input  logic              dataAvailIn,
  input  logic              irqSetEn,
  input  logic [FLAG_W-1:0] irqSetCode,
  input  logic              rspPushEn,
  input  logic [DATA_W-1:0] rspPushData,
  input  logic              parPopEn,
  output logic [DATA_W-1:0] parHead,
  output logic              cmdValid,
  output logic [DATA_W-1:0] cmdByte,
  output logic              irqOut,
  output logic [DATA_W-1:0] mixOut [MIX_N]
);
  localparam int PAD_W = DATA_W - FLAG_W;
  localparam logic [PAD_W-1:0] PAD_ONES = '1;

  logic              parEmpty, parFull, rspEmpty, rspFull;
  logic [DATA_W-1:0] rspHead;
  logic [FLAG_W-1:0] flagReg, maskReg, clrBits, setBits;
  logic [DATA_W-1:0] statusByte;

  hr_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_parFifo (
    .clk(clk), .rstN(rstN),
    .clr(strb.wrClr && busWrData[6]),
    .push(strb.pushPar), .pushData(busWrData),
    .pop(parPopEn), .head(parHead),
    .empty(parEmpty), .full(parFull));

  hr_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_rspFifo (
    .clk(clk), .rstN(rstN), .clr(1'b0),
    .push(rspPushEn), .pushData(rspPushData),
    .pop(strb.popRsp), .head(rspHead),
    .empty(rspEmpty), .full(rspFull));

  assign clrBits = strb.wrClr ? busWrData[FLAG_W-1:0] : '0;
  assign setBits = irqSetEn   ? irqSetCode            : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagReg  <= '0;
      maskReg  <= '0;
      cmdValid <= 1'b0;
      cmdByte  <= '0;
    end else begin
      flagReg  <= (flagReg & ~clrBits) | setBits;
      if (strb.wrMask) maskReg <= busWrData[FLAG_W-1:0];
      cmdValid <= strb.wrCmd;
      if (strb.wrCmd) cmdByte <= busWrData;
    end
  end

  for (genvar g = 0; g < MIX_N; g++) begin : g_mix
    always_ff @(posedge clk) begin
      if (!rstN)              mixOut[g] <= '0;
      else if (strb.wrMix[g]) mixOut[g] <= busWrData;
    end
  end

  assign irqOut = |(flagReg & maskReg);

  assign statusByte = {busyIn, dataAvailIn, !rspEmpty, !parFull, parEmpty,
                       1'b0, bankIdx};

  always_comb begin
    unique case (busAddr)
      2'd0: busRdData = statusByte;
      2'd1: busRdData = rspHead;
      2'd3: begin
        if (bankIdx == 2'd0)      busRdData = {PAD_ONES, maskReg};
        else if (bankIdx == 2'd1) busRdData = {PAD_ONES, flagReg};
        else                      busRdData = '0;
      end
      default: busRdData = '0;
    endcase
  end

  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    irqSetEn |=> (flagReg & $past(irqSetCode)) == $past(irqSetCode));

  a_r8_clear_bits: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClr && !irqSetEn |=> (flagReg & $past(busWrData[FLAG_W-1:0])) == '0);

  a_r10_cmd_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCmd |=> cmdValid && cmdByte == $past(busWrData));

  a_r10_cmd_single: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !strb.wrCmd |=> !cmdValid);

  a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrMask |=> $stable(maskReg));
endmodule

// File: rtl/disc_host_port.sv
module disc_host_port
  import hostregs_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  busAddr,
  input  logic        busWrEn,
  input  logic [7:0]  busWrData,
  input  logic        busRdEn,
  output logic [7:0]  busRdData,
  input  logic        busyIn,
  input  logic        dataAvailIn,
  input  logic        irqSetEn,
  input  logic [4:0]  irqSetCode,
  input  logic        rspPushEn,
  input  logic [7:0]  rspPushData,
  input  logic        parPopEn,
  output logic [7:0]  parHead,
  output logic        cmdValid,
  output logic [7:0]  cmdByte,
  output logic        irqOut,
  output logic [7:0]  mixLeftLeft,
  output logic [7:0]  mixLeftRight,
  output logic [7:0]  mixRightLeft,
  output logic [7:0]  mixRightRight
);
  hrStrobes_t        strb;
  logic [1:0]        bankIdx;
  logic [DATA_W-1:0] mixOut [MIX_N];

  hr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .bankIdx(bankIdx), .strb(strb));

  hr_datapath #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bankIdx(bankIdx),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .busyIn(busyIn), .dataAvailIn(dataAvailIn),
    .irqSetEn(irqSetEn), .irqSetCode(irqSetCode),
    .rspPushEn(rspPushEn), .rspPushData(rspPushData),
    .parPopEn(parPopEn), .parHead(parHead),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .irqOut(irqOut),
    .mixOut(mixOut));

  assign mixLeftLeft   = mixOut[MIX_LL];
  assign mixLeftRight  = mixOut[MIX_LR];
  assign mixRightLeft  = mixOut[MIX_RL];
  assign mixRightRight = mixOut[MIX_RR];
endmodule

// File: tb/sim_disc_host_port.sv
`timescale 1ns/1ps
module sim_disc_host_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic       busRdEn = 1'b0;
  logic [7:0] busRdData;
  logic       busyIn = 1'b0, dataAvailIn = 1'b0;
  logic       irqSetEn = 1'b0;
  logic [4:0] irqSetCode = '0;
  logic       rspPushEn = 1'b0;
  logic [7:0] rspPushData = '0;
  logic       parPopEn = 1'b0;
  logic [7:0] parHead, cmdByte;
  logic       cmdValid, irqOut;
  logic [7:0] mixLL, mixLR, mixRL, mixRR;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  disc_host_port u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .busyIn(busyIn), .dataAvailIn(dataAvailIn), .irqSetEn(irqSetEn),
    .irqSetCode(irqSetCode), .rspPushEn(rspPushEn), .rspPushData(rspPushData),
    .parPopEn(parPopEn), .parHead(parHead), .cmdValid(cmdValid),
    .cmdByte(cmdByte), .irqOut(irqOut), .mixLeftLeft(mixLL),
    .mixLeftRight(mixLR), .mixRightLeft(mixRL), .mixRightRight(mixRR));

  // {bank, offset, data, mix select 0=LL 1=LR 2=RL 3=RR}
  localparam logic [13:0] MIX_VEC [8] = '{
    {2'd2, 2'd2, 8'h11, 2'd0}, {2'd2, 2'd3, 8'h22, 2'd1},
    {2'd3, 2'd2, 8'h33, 2'd2}, {2'd3, 2'd1, 8'h44, 2'd3},
    {2'd3, 2'd1, 8'h55, 2'd3}, {2'd2, 2'd2, 8'h66, 2'd0},
    {2'd2, 2'd3, 8'h77, 2'd1}, {2'd3, 2'd2, 8'h88, 2'd2}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic setBank(input logic [1:0] b);
    busWrite(2'd0, {6'd0, b});
  endtask

  task automatic rspPush(input logic [7:0] d);
    @(negedge clk);
    rspPushData = d; rspPushEn = 1'b1;
    @(negedge clk);
    rspPushEn = 1'b0;
  endtask

  task automatic flagSet(input logic [4:0] c);
    @(negedge clk);
    irqSetCode = c; irqSetEn = 1'b1;
    @(negedge clk);
    irqSetEn = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] expMix [4];
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(2'd0, rd); chk("R1 status", rd, 8'h18);
    chk("R1 irq", {7'd0, irqOut}, 8'h00);
    chk("R1 cmdValid", {7'd0, cmdValid}, 8'h00);
    busRead(2'd3, rd); chk("R1 mask read", rd, 8'hE0);
    setBank(2'd1);
    busRead(2'd3, rd); chk("R1 flag read", rd, 8'hE0);
    chk("R1 mix", mixLL | mixLR | mixRL | mixRR, 8'h00);

    // R2 index uses low two bits
    busWrite(2'd0, 8'hFE);
    busRead(2'd0, rd); chk("R2 index in status", rd, 8'h1A);
    setBank(2'd0);

    // R3 status bits
    @(negedge clk); busyIn = 1'b1; dataAvailIn = 1'b1;
    busRead(2'd0, rd); chk("R3 busy/avail", rd, 8'hD8);
    rspPush(8'h5A);
    busRead(2'd0, rd); chk("R3 rsp not empty", rd, 8'hF8);
    @(negedge clk); busyIn = 1'b0; dataAvailIn = 1'b0;
    busRead(2'd1, rd); chk("R6 pop value", rd, 8'h5A);
    busRead(2'd0, rd); chk("R3 rsp empty again", rd, 8'h18);

    // R4 parameter queue fill and order
    for (int i = 0; i < 16; i++) busWrite(2'd2, 8'h10 + 8'(i));
    busRead(2'd0, rd); chk("R4 full status", rd, 8'h00);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1 chk("R4 head order", parHead, 8'h10 + 8'(i));
      parPopEn = 1'b1; @(negedge clk); parPopEn = 1'b0;
    end
    busRead(2'd0, rd); chk("R4 not full after pops", rd, 8'h10);

    // R8 bit 6 flushes parameter queue
    setBank(2'd1);
    busWrite(2'd3, 8'h40);
    busRead(2'd0, rd); chk("R8 param flush", rd, 8'h19);
    setBank(2'd0);

    // R5 overflow wrap
    for (int i = 0; i < 17; i++) busWrite(2'd2, 8'h80 + 8'(i));
    @(negedge clk); #1 chk("R5 folded head", parHead, 8'h90);
    busRead(2'd0, rd); chk("R5 17 pushes status", rd, 8'h10);
    for (int i = 0; i < 15; i++) busWrite(2'd2, 8'hA0 + 8'(i));
    busRead(2'd0, rd); chk("R5 32 pushes empty", rd, 8'h18);

    // R6 response drain and empty read
    for (int i = 0; i < 16; i++) rspPush(8'h30 + 8'(i));
    for (int i = 0; i < 16; i++) begin
      busRead(2'd1, rd); chk("R6 response order", rd, 8'h30 + 8'(i));
    end
    busRead(2'd1, rd); chk("R6 empty read", rd, 8'h30);
    busRead(2'd1, rd); chk("R6 empty read repeat", rd, 8'h30);
    busRead(2'd0, rd); chk("R6 still empty", rd, 8'h18);

    // R7 / R9 / R12 / R8 interrupt path
    setBank(2'd1);
    busWrite(2'd2, 8'hFF);
    setBank(2'd0);
    busRead(2'd3, rd); chk("R7 mask read", rd, 8'hFF);
    chk("R9 no flags no irq", {7'd0, irqOut}, 8'h00);
    flagSet(5'h03);
    chk("R9 irq high", {7'd0, irqOut}, 8'h01);
    setBank(2'd1);
    busRead(2'd3, rd); chk("R12 flags set", rd, 8'hE3);
    busWrite(2'd3, 8'h01);
    busRead(2'd3, rd); chk("R8 partial clear", rd, 8'hE2);
    busWrite(2'd2, 8'hE4);
    @(negedge clk); chk("R9 masked off", {7'd0, irqOut}, 8'h00);
    setBank(2'd0);
    busRead(2'd3, rd); chk("R9 mask low bits", rd, 8'hE4);
    setBank(2'd1);
    @(negedge clk);
    busAddr = 2'd3; busWrData = 8'h1F; busWrEn = 1'b1;
    irqSetCode = 5'h04; irqSetEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; irqSetEn = 1'b0;
    busRead(2'd3, rd); chk("R12 set wins", rd, 8'hE4);
    chk("R9 irq on matching bit", {7'd0, irqOut}, 8'h01);
    busWrite(2'd3, 8'h1F);
    busRead(2'd3, rd); chk("R8 full clear", rd, 8'hE0);
    chk("R8 irq low", {7'd0, irqOut}, 8'h00);

    // R10 command handshake
    setBank(2'd0);
    busWrite(2'd1, 8'h1B);
    #1 chk("R10 pulse", {7'd0, cmdValid}, 8'h01);
    chk("R10 byte", cmdByte, 8'h1B);
    @(negedge clk); chk("R10 pulse ends", {7'd0, cmdValid}, 8'h00);

    // R11 mix mapping, table walk
    for (int k = 0; k < 4; k++) expMix[k] = 8'h00;
    for (int v = 0; v < 8; v++) begin
      setBank(MIX_VEC[v][13:12]);
      busWrite(MIX_VEC[v][11:10], MIX_VEC[v][9:2]);
      expMix[MIX_VEC[v][1:0]] = MIX_VEC[v][9:2];
      #1;
      chk("R11 left-left", mixLL, expMix[0]);
      chk("R11 left-right", mixLR, expMix[1]);
      chk("R11 right-left", mixRL, expMix[2]);
      chk("R11 right-right", mixRR, expMix[3]);
      chk("R10 no pulse from mix write", {7'd0, cmdValid}, 8'h00);
    end
    // writes in banks that hold no mix register
    setBank(2'd1);
    busWrite(2'd1, 8'hEE);
    #1 chk("R10 bank1 offset1 no pulse", {7'd0, cmdValid}, 8'h00);
    chk("R11 unchanged", mixRR, expMix[3]);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule